// File: doc/BRIEF.md
# Range Maintenance Line Walker

This sequencer turns one cache maintenance command into a series of per-line actions on a set-associative tag store. A command gives a start address, an end address and an operation: invalidate, clean or flush. The walker first widens the range to whole lines. The start moves down to a line boundary, and the length from that boundary to the end is rounded up to a whole number of lines. It then visits each line in turn, looks it up in the tag store, and issues tag updates and writeback requests as the operation requires.

Long ranges are cut into chunks of a bounded number of lines, and each chunk is announced with a strobe. A range whose length comes within one line of the size of the address space is not walked by address. It becomes a whole-cache pass that reads every set and way by index. After the last line, the walker issues a one-cycle drain strobe and then a one-cycle done strobe. Only after that does it take a new command. The writeback data path and the tag memory sit outside the block.

Top module: `rmw_line_walker`

## Requirements
- R1: After reset, cmd_ready_o is 1 and lkp_valid_o, upd_valid_o, wb_req_o, chunk_o, sync_o and done_o are all 0.
- R2: In range mode, the aligned start is cmd_start_i with its low log2(LINE_BYTES) bits cleared. The size is (cmd_end_i − aligned start) modulo 2^ADDR_W. The walker looks up exactly ceil(size/LINE_BYTES) line addresses, in ascending order from the aligned start and wrapping modulo 2^ADDR_W, with lkp_index_o = 0.
- R3: A size of at least 2^ADDR_W − LINE_BYTES gives a whole-cache pass. This pass makes NUM_SETS×NUM_WAYS lookups with lkp_index_o = 1, the set in lkp_addr_o bits [LINE_LG +: SET_W] and the way in lkp_way_o. The order is set 0 way 0 first, way incrementing before set. No chunk strobes are issued. One byte less than the threshold is still a range walk.
- R4: In range mode, each chunk begins with a one-cycle chunk_o carrying chunk_lines_o. chunk_lines_o is between 1 and MAX_RANGE_BYTES/LINE_BYTES − 1. Every chunk except the last has the maximum length, and the chunk lengths add up to the line count.
- R5: Operation code 0 (invalidate) clears the valid and dirty bits of every hit line and never requests a writeback.
- R6: Operation code 1 (clean) writes back every dirty hit line and then clears its dirty bit while keeping it valid. It leaves clean lines untouched.
- R7: Operation code 2 (flush) writes back every dirty hit line and then invalidates it. It invalidates clean hit lines without a writeback.
- R8: Once wb_req_o is raised, it stays high with wb_set_o and wb_way_o unchanged until wb_ack_i is sampled high. Only then does the walk continue.
- R9: A command whose aligned size is zero makes no lookup and no chunk, and completes with only the drain strobe.
- R10: Each command ends with exactly one single-cycle sync_o. It is followed in the next cycle by a single-cycle done_o, and cmd_ready_o rises in the cycle after done_o.
- R11: cmd_ready_o is 0 from the cycle after acceptance through the done cycle. A command offered in that window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Walker idle, command taken when valid |
| cmd_op_i | input | 2 | 0 invalidate, 1 clean, 2 flush |
| cmd_start_i | input | ADDR_W | Range start byte address |
| cmd_end_i | input | ADDR_W | Range end byte address (exclusive) |
| lkp_valid_o | output | 1 | Tag lookup strobe |
| lkp_index_o | output | 1 | 1: look up by set/way index, 0: by address |
| lkp_addr_o | output | ADDR_W | Line address, or set index in the set field |
| lkp_way_o | output | WAY_W | Way for index lookups |
| lkp_hit_i | input | 1 | Line present (valid at index) |
| lkp_dirty_i | input | 1 | Line dirty |
| lkp_way_i | input | WAY_W | Way holding the line |
| upd_valid_o | output | 1 | Tag update strobe |
| upd_set_o | output | SET_W | Set to update |
| upd_way_o | output | WAY_W | Way to update |
| upd_clr_valid_o | output | 1 | Clear valid bit |
| upd_clr_dirty_o | output | 1 | Clear dirty bit |
| wb_req_o | output | 1 | Writeback request, held until acknowledged |
| wb_set_o | output | SET_W | Set of line to write back |
| wb_way_o | output | WAY_W | Way of line to write back |
| wb_ack_i | input | 1 | Writeback accepted |
| chunk_o | output | 1 | Start of a chunk |
| chunk_lines_o | output | ADDR_W−LINE_LG | Lines in the starting chunk |
| sync_o | output | 1 | Drain strobe after the last line |
| done_o | output | 1 | Command complete |

## Verification
The assertions take for granted that the tag store answers a lookup combinationally in the same cycle. They also assume at most one way of a set matches a given address, and that wb_ack_i is only raised while wb_req_o is high. The bench's tag model meets these assumptions by construction. Each preloaded set gets distinct tags per way, and acknowledges come from a registered responder that only counts while a request is pending. Commands are offered only while the walker is idle, except in the deliberate busy test, and reserved operation code 3 is never driven.

// File: rtl/rmw_pkg.sv
`timescale 1ns/1ps
package rmw_pkg;
  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHUNK,
    ST_LOOK,
    ST_WB,
    ST_SYNC,
    ST_DONE
  } st_e;
endpackage

// File: rtl/rmw_range.sv
`timescale 1ns/1ps
module rmw_range #(
  parameter int ADDR_W  = 12,
  parameter int LINE_LG = 4,
  localparam int CNT_W  = ADDR_W - LINE_LG
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  output logic [ADDR_W-1:0] astart_o,
  output logic              all_o,
  output logic [CNT_W-1:0]  lines_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << LINE_LG) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WRAP_LIM = ~LOW_MASK;

  logic [ADDR_W-1:0] size;

  always_comb begin
    astart_o = start_i & ~LOW_MASK;
    size     = end_i - astart_o;
    all_o    = (size >= WRAP_LIM);
    // round up; cannot overflow unless all_o
    lines_o  = size[ADDR_W-1:LINE_LG] + CNT_W'(|size[LINE_LG-1:0]);
  end
endmodule

// File: rtl/rmw_line_act.sv
`timescale 1ns/1ps
module rmw_line_act
  import rmw_pkg::*;
(
  input  op_e  op_i,
  input  logic hit_i,
  input  logic dirty_i,
  output logic look_wb_o,
  output logic look_upd_o,
  output logic look_clr_valid_o,
  output logic look_clr_dirty_o,
  output logic wb_clr_valid_o
);
  always_comb begin
    look_wb_o        = 1'b0;
    look_upd_o       = 1'b0;
    look_clr_valid_o = 1'b0;
    look_clr_dirty_o = 1'b0;
    if (hit_i) begin
      unique case (op_i)
        OP_INV: begin
          look_upd_o       = 1'b1;
          look_clr_valid_o = 1'b1;
          look_clr_dirty_o = 1'b1;
        end
        OP_FLUSH: begin
          look_wb_o        = dirty_i;
          look_upd_o       = !dirty_i;
          look_clr_valid_o = 1'b1;
          look_clr_dirty_o = 1'b1;
        end
        default: look_wb_o = dirty_i; // clean, reserved
      endcase
    end
    wb_clr_valid_o = (op_i == OP_FLUSH);
  end
endmodule

// File: rtl/rmw_cursor.sv
`timescale 1ns/1ps
module rmw_cursor #(
  parameter int ADDR_W      = 12,
  parameter int LINE_LG     = 4,
  parameter int NUM_SETS    = 8,
  parameter int NUM_WAYS    = 2,
  parameter int CHUNK_LINES = 7,
  localparam int CNT_W      = ADDR_W - LINE_LG,
  localparam int SET_W      = $clog2(NUM_SETS),
  localparam int WAY_W      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              load_all_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [CNT_W-1:0]  load_lines_i,
  input  logic              chunk_go_i,
  input  logic              step_i,
  output logic              all_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WAY_W-1:0]  way_o,
  output logic              last_o,
  output logic              chunk_last_o,
  output logic [CNT_W-1:0]  chunk_len_o
);
  localparam logic [ADDR_W-1:0] LINE_INC = ADDR_W'(1) << LINE_LG;
  localparam logic [CNT_W-1:0]  CHUNK_MAX = CNT_W'(CHUNK_LINES);

  logic              all_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SET_W-1:0]  set_q;
  logic [WAY_W-1:0]  way_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  chunk_q;
  logic              way_wrap;
  logic              set_last;

  assign way_wrap = (way_q == WAY_W'(NUM_WAYS - 1));
  assign set_last = (set_q == SET_W'(NUM_SETS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      all_q   <= 1'b0;
      addr_q  <= '0;
      set_q   <= '0;
      way_q   <= '0;
      left_q  <= '0;
      chunk_q <= '0;
    end else if (load_i) begin
      all_q  <= load_all_i;
      addr_q <= load_addr_i;
      set_q  <= '0;
      way_q  <= '0;
      left_q <= load_lines_i;
    end else begin
      if (chunk_go_i) chunk_q <= chunk_len_o;
      if (step_i) begin
        if (all_q) begin
          way_q <= way_wrap ? '0 : way_q + WAY_W'(1);
          if (way_wrap) set_q <= set_q + SET_W'(1);
        end else begin
          addr_q  <= addr_q + LINE_INC;
          left_q  <= left_q - CNT_W'(1);
          chunk_q <= chunk_q - CNT_W'(1);
        end
      end
    end
  end

  assign all_o        = all_q;
  assign addr_o       = all_q ? (ADDR_W'(set_q) << LINE_LG) : addr_q;
  assign way_o        = way_q;
  assign last_o       = all_q ? (set_last && way_wrap) : (left_q == CNT_W'(1));
  assign chunk_last_o = (chunk_q == CNT_W'(1));
  assign chunk_len_o  = (left_q < CHUNK_MAX) ? left_q : CHUNK_MAX;

  // R3
  all_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_q && step_i && !load_i && way_wrap |=> way_q == '0);
endmodule

// File: rtl/rmw_line_walker.sv
`timescale 1ns/1ps
module rmw_line_walker
  import rmw_pkg::*;
#(
  parameter int ADDR_W          = 12,
  parameter int LINE_BYTES      = 16,
  parameter int NUM_SETS        = 8,
  parameter int NUM_WAYS        = 2,
  parameter int MAX_RANGE_BYTES = 128,
  localparam int LINE_LG        = $clog2(LINE_BYTES),
  localparam int SET_W          = $clog2(NUM_SETS),
  localparam int WAY_W          = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int CNT_W          = ADDR_W - LINE_LG,
  localparam int CHUNK_LINES    = MAX_RANGE_BYTES / LINE_BYTES - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_start_i,
  input  logic [ADDR_W-1:0] cmd_end_i,
  output logic              lkp_valid_o,
  output logic              lkp_index_o,
  output logic [ADDR_W-1:0] lkp_addr_o,
  output logic [WAY_W-1:0]  lkp_way_o,
  input  logic              lkp_hit_i,
  input  logic              lkp_dirty_i,
  input  logic [WAY_W-1:0]  lkp_way_i,
  output logic              upd_valid_o,
  output logic [SET_W-1:0]  upd_set_o,
  output logic [WAY_W-1:0]  upd_way_o,
  output logic              upd_clr_valid_o,
  output logic              upd_clr_dirty_o,
  output logic              wb_req_o,
  output logic [SET_W-1:0]  wb_set_o,
  output logic [WAY_W-1:0]  wb_way_o,
  input  logic              wb_ack_i,
  output logic              chunk_o,
  output logic [CNT_W-1:0]  chunk_lines_o,
  output logic              sync_o,
  output logic              done_o
);
  st_e  st_q, st_d, adv_st;
  op_e  op_q;
  logic [SET_W-1:0] ent_set_q;
  logic [WAY_W-1:0] ent_way_q;

  logic [ADDR_W-1:0] rng_astart;
  logic              rng_all;
  logic [CNT_W-1:0]  rng_lines;

  logic              accept, step, chunk_go;
  logic              cur_all, cur_last, chunk_last;
  logic [CNT_W-1:0]  chunk_len;

  logic look_wb, look_upd, look_clr_valid, look_clr_dirty, wb_clr_valid;
  logic in_look, in_wb;

  rmw_range #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG)) range_i (
    .start_i  (cmd_start_i),
    .end_i    (cmd_end_i),
    .astart_o (rng_astart),
    .all_o    (rng_all),
    .lines_o  (rng_lines)
  );

  rmw_cursor #(
    .ADDR_W(ADDR_W), .LINE_LG(LINE_LG), .NUM_SETS(NUM_SETS),
    .NUM_WAYS(NUM_WAYS), .CHUNK_LINES(CHUNK_LINES)
  ) cursor_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (accept),
    .load_all_i   (rng_all),
    .load_addr_i  (rng_astart),
    .load_lines_i (rng_lines),
    .chunk_go_i   (chunk_go),
    .step_i       (step),
    .all_o        (cur_all),
    .addr_o       (lkp_addr_o),
    .way_o        (lkp_way_o),
    .last_o       (cur_last),
    .chunk_last_o (chunk_last),
    .chunk_len_o  (chunk_len)
  );

  rmw_line_act act_i (
    .op_i             (op_q),
    .hit_i            (lkp_hit_i),
    .dirty_i          (lkp_dirty_i),
    .look_wb_o        (look_wb),
    .look_upd_o       (look_upd),
    .look_clr_valid_o (look_clr_valid),
    .look_clr_dirty_o (look_clr_dirty),
    .wb_clr_valid_o   (wb_clr_valid)
  );

  assign in_look  = (st_q == ST_LOOK);
  assign in_wb    = (st_q == ST_WB);
  assign accept   = (st_q == ST_IDLE) && cmd_valid_i;
  assign chunk_go = (st_q == ST_CHUNK);
  assign step     = (in_look && !look_wb) || (in_wb && wb_ack_i);

  always_comb begin
    if (cur_last)                  adv_st = ST_SYNC;
    else if (!cur_all && chunk_last) adv_st = ST_CHUNK;
    else                           adv_st = ST_LOOK;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (cmd_valid_i)
                  st_d = rng_all ? ST_LOOK : ((rng_lines == '0) ? ST_SYNC : ST_CHUNK);
      ST_CHUNK: st_d = ST_LOOK;
      ST_LOOK:  st_d = look_wb ? ST_WB : adv_st;
      ST_WB:    if (wb_ack_i) st_d = adv_st;
      ST_SYNC:  st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_INV;
      ent_set_q <= '0;
      ent_way_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) op_q <= op_e'(cmd_op_i);
      if (in_look && look_wb) begin
        ent_set_q <= lkp_addr_o[LINE_LG +: SET_W];
        ent_way_q <= lkp_way_i;
      end
    end
  end

  assign cmd_ready_o     = (st_q == ST_IDLE);
  assign lkp_valid_o     = in_look;
  assign lkp_index_o     = cur_all;
  assign upd_valid_o     = (in_look && look_upd) || (in_wb && wb_ack_i);
  assign upd_set_o       = in_wb ? ent_set_q : lkp_addr_o[LINE_LG +: SET_W];
  assign upd_way_o       = in_wb ? ent_way_q : lkp_way_i;
  assign upd_clr_valid_o = upd_valid_o && (in_wb ? wb_clr_valid : look_clr_valid);
  assign upd_clr_dirty_o = upd_valid_o && (in_wb || look_clr_dirty);
  assign wb_req_o        = in_wb;
  assign wb_set_o        = ent_set_q;
  assign wb_way_o        = ent_way_q;
  assign chunk_o         = chunk_go;
  assign chunk_lines_o   = chunk_go ? chunk_len : '0;
  assign sync_o          = (st_q == ST_SYNC);
  assign done_o          = (st_q == ST_DONE);

  // R8
  wb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o && !wb_ack_i |=> wb_req_o && $stable(wb_set_o) && $stable(wb_way_o));
  // R8
  wb_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wb_req_o) |-> $past(wb_ack_i));
  // R10
  sync_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(sync_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && cmd_ready_o);
  // R11
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o && cmd_valid_i |=> !cmd_ready_o);
  // R4
  chunk_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_o |-> (chunk_lines_o != '0) && (chunk_lines_o <= CNT_W'(CHUNK_LINES)));
  // R5
  inv_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> op_q != OP_INV);
  // R6
  clean_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o && (op_q == OP_CLEAN) |-> !upd_clr_valid_o);
endmodule

// File: tb/rmw_line_walker_tb_top.sv
`timescale 1ns/1ps
module rmw_line_walker_tb_top;
  localparam int AW = 12, NS = 8, NW = 2, CL = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [11:0] cmd_start = '0, cmd_end = '0;
  logic        lkp_valid, lkp_index, lkp_hit, lkp_dirty;
  logic [11:0] lkp_addr;
  logic        lkp_way, lkp_way_r;
  logic        upd_valid, upd_clr_valid, upd_clr_dirty;
  logic [2:0]  upd_set, wb_set;
  logic        upd_way, wb_way;
  logic        wb_req, wb_ack = 1'b0;
  logic        chunk;
  logic [7:0]  chunk_lines;
  logic        sync_s, done_s;

  rmw_line_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_start_i(cmd_start), .cmd_end_i(cmd_end),
    .lkp_valid_o(lkp_valid), .lkp_index_o(lkp_index), .lkp_addr_o(lkp_addr),
    .lkp_way_o(lkp_way), .lkp_hit_i(lkp_hit), .lkp_dirty_i(lkp_dirty),
    .lkp_way_i(lkp_way_r),
    .upd_valid_o(upd_valid), .upd_set_o(upd_set), .upd_way_o(upd_way),
    .upd_clr_valid_o(upd_clr_valid), .upd_clr_dirty_o(upd_clr_dirty),
    .wb_req_o(wb_req), .wb_set_o(wb_set), .wb_way_o(wb_way), .wb_ack_i(wb_ack),
    .chunk_o(chunk), .chunk_lines_o(chunk_lines), .sync_o(sync_s), .done_o(done_s)
  );

  // tag store model
  logic [4:0] tag_m [NS][NW];
  logic       val_m [NS][NW];
  logic       dty_m [NS][NW];

  function automatic logic [4:0] f_tag(int sd, int s, int w);
    return 5'((((sd + s) % 4) << 1) | w);
  endfunction
  function automatic logic f_val(int sd, int s, int w);
    return ((sd + s * 3 + w * 5) % 5) != 0;
  endfunction
  function automatic logic f_dty(int sd, int s, int w);
    return f_val(sd, s, w) && (((sd + s + w * 2) % 3) == 0);
  endfunction

  always @* begin
    lkp_hit = 1'b0; lkp_dirty = 1'b0; lkp_way_r = 1'b0;
    if (lkp_index) begin
      lkp_hit   = val_m[lkp_addr[6:4]][lkp_way];
      lkp_dirty = dty_m[lkp_addr[6:4]][lkp_way];
      lkp_way_r = lkp_way;
    end else begin
      for (int w = 0; w < NW; w++)
        if (val_m[lkp_addr[6:4]][w] && tag_m[lkp_addr[6:4]][w] == lkp_addr[11:7]) begin
          lkp_hit = 1'b1; lkp_dirty = dty_m[lkp_addr[6:4]][w]; lkp_way_r = 1'(w);
        end
    end
  end

  int  seed_r = 0, ack_dly = 0, ack_cnt = 0;
  logic load_req = 1'b0, mon_clr = 1'b0, exp_all = 1'b0;
  int  exp_base = 0;
  int  n_lkp = 0, n_wb = 0, n_chunk = 0, chunk_sum = 0, chunk_max = 0, n_sync = 0, mon_err = 0;
  logic short_seen = 1'b0, prev_hold = 1'b0, prev_sync = 1'b0;
  logic [2:0] prev_set = '0;
  logic prev_way = 1'b0;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always @(posedge clk) begin
    if (load_req) begin
      for (int s = 0; s < NS; s++)
        for (int w = 0; w < NW; w++) begin
          tag_m[s][w] <= f_tag(seed_r, s, w);
          val_m[s][w] <= f_val(seed_r, s, w);
          dty_m[s][w] <= f_dty(seed_r, s, w);
        end
    end else if (upd_valid) begin
      if (upd_clr_valid) val_m[upd_set][upd_way] <= 1'b0;
      if (upd_clr_dirty) dty_m[upd_set][upd_way] <= 1'b0;
    end
    if (wb_req && !wb_ack) begin
      if (ack_cnt >= ack_dly) begin wb_ack <= 1'b1; ack_cnt <= 0; end
      else ack_cnt <= ack_cnt + 1;
    end else wb_ack <= 1'b0;
    if (mon_clr) begin
      n_lkp <= 0; n_wb <= 0; n_chunk <= 0; chunk_sum <= 0; chunk_max <= 0;
      n_sync <= 0; mon_err <= 0; short_seen <= 1'b0;
    end else begin
      if (lkp_valid) begin
        n_lkp <= n_lkp + 1;
        if (exp_all) begin
          if (!lkp_index || lkp_addr[6:4] != 3'(n_lkp / NW) || lkp_way != 1'(n_lkp % NW))
            mon_err <= mon_err + 1;
        end else if (lkp_index || lkp_addr != 12'((exp_base + n_lkp * 16) % 4096))
          mon_err <= mon_err + 1;
      end
      if (wb_req && wb_ack) n_wb <= n_wb + 1;
      if (chunk) begin
        n_chunk <= n_chunk + 1;
        chunk_sum <= chunk_sum + int'(chunk_lines);
        if (int'(chunk_lines) > chunk_max) chunk_max <= int'(chunk_lines);
        if (short_seen) mon_err <= mon_err + 1;
        if (int'(chunk_lines) < CL) short_seen <= 1'b1;
      end
      if (sync_s) n_sync <= n_sync + 1;
      if (done_s && !prev_sync) mon_err <= mon_err + 1;
      if (prev_hold && !(wb_req && wb_set == prev_set && wb_way == prev_way))
        mon_err <= mon_err + 1;
      if (wb_req && lkp_valid) mon_err <= mon_err + 1;
    end
    prev_sync <= sync_s;
    prev_hold <= wb_req && !wb_ack;
    prev_set  <= wb_set;
    prev_way  <= wb_way;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic run_cmd(input int op, input int st, input int en, input int sd, input bit busy);
    int astart, size, nl, e_lkp, e_chunks, e_cmax, e_wb, bad;
    bit all;
    @(negedge clk);
    seed_r = sd; ack_dly = sd % 3; load_req = 1'b1; mon_clr = 1'b1;
    @(negedge clk);
    load_req = 1'b0; mon_clr = 1'b0;
    astart = st & 32'hFF0;
    size = (en - astart + 4096) % 4096;
    all = size >= 4080;
    nl = all ? 0 : (size + 15) / 16;
    e_lkp = all ? NS * NW : nl;
    e_chunks = all ? 0 : (nl + CL - 1) / CL;
    e_cmax = all ? 0 : ((nl < CL) ? nl : CL);
    exp_all = all; exp_base = astart;
    e_wb = 0; bad = 0;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        int la = int'(f_tag(sd, s, w)) * 128 + s * 16;
        bit cov = all || (((la - astart + 4096) % 4096) < nl * 16);
        if (cov && f_dty(sd, s, w) && op != 0) e_wb++;
      end
    cmd_op = 2'(op); cmd_start = 12'(st); cmd_end = 12'(en); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (busy) begin
      @(negedge clk);
      cmd_op = 2'd2; cmd_start = 12'h000; cmd_end = 12'h3FF; cmd_valid = 1'b1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R11 ready low while busy", int'(cmd_ready), 0);
      end
      cmd_valid = 1'b0;
    end
    while (!done_s) @(negedge clk);
    chk(cmd_ready == 1'b0, "R11 ready low in done cycle", int'(cmd_ready), 0);
    @(negedge clk);
    chk(cmd_ready && !done_s, "R10 done single cycle then ready", int'({cmd_ready, done_s}), 2);
    repeat (3) @(negedge clk);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        int la = int'(f_tag(sd, s, w)) * 128 + s * 16;
        bit cov = all || (((la - astart + 4096) % 4096) < nl * 16);
        bit v0 = f_val(sd, s, w), d0 = f_dty(sd, s, w);
        bit ev = v0, ed = d0;
        if (cov && v0) begin
          if (op == 0 || op == 2) begin ev = 0; ed = 0; end
          else ed = 0;
        end
        if (val_m[s][w] != ev || (ev && dty_m[s][w] != ed)) bad++;
      end
    chk(n_lkp == e_lkp, all ? "R3 lookup count" : (nl == 0 ? "R9 no lookups" : "R2 lookup count"), n_lkp, e_lkp);
    chk(n_chunk == e_chunks, "R4 chunk count", n_chunk, e_chunks);
    chk(chunk_max == e_cmax, "R4 chunk max length", chunk_max, e_cmax);
    chk(all || chunk_sum == nl, "R4 chunk sum", chunk_sum, nl);
    chk(n_wb == e_wb, op == 0 ? "R5 no writeback" : (op == 1 ? "R6 writebacks" : "R7 writebacks"), n_wb, e_wb);
    chk(bad == 0, op == 0 ? "R5 tag state" : (op == 1 ? "R6 tag state" : "R7 tag state"), bad, 0);
    chk(mon_err == 0, "R2 R3 R8 order and hold", mon_err, 0);
    chk(n_sync == 1, "R10 one sync", n_sync, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cmd_ready && !lkp_valid && !upd_valid && !wb_req && !chunk && !sync_s && !done_s,
        "R1 reset state", int'({cmd_ready, lkp_valid, upd_valid, wb_req, chunk, sync_s, done_s}), 64);
    run_cmd(0, 12'h000, 12'h100, 1, 0);   // R5, chunks 7,7,2
    run_cmd(1, 12'h105, 12'h233, 2, 0);   // R6 unaligned start
    run_cmd(2, 12'h040, 12'h3C1, 3, 0);   // R7 unaligned end
    run_cmd(2, 12'h123, 12'h120, 4, 0);   // R9 zero after alignment
    run_cmd(1, 12'h200, 12'h200, 5, 0);   // R9 empty aligned
    run_cmd(2, 12'h010, 12'h000, 6, 0);   // R3 at wrap threshold
    run_cmd(1, 12'h010, 12'hFFF, 7, 0);   // R3 one byte below threshold
    run_cmd(0, 12'h000, 12'h000, 8, 0);   // R3 size zero? no: astart 0 size 0 -> R9
    run_cmd(0, 12'h0F0, 12'h2F0, 9, 1);   // R11 busy offer ignored
    for (int i = 0; i < 24; i++)
      run_cmd(i % 3, (i * 77) % 1024, ((i * 77) % 1024 + (i * 53) % 400) % 4096, i + 10, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule